// File: doc/BRIEF.md
# Serial Flash Word-Stream Programming Sequencer

This block writes a range of bytes from a local source buffer into a serial NOR flash. It uses the device's auto-incrementing two-byte program mode. The address is sent once, and each later frame carries only the opcode and the next two bytes. The device is busy after every frame, so the sequencer reads the status register until the busy bit drops before it sends the next frame.

Word mode accepts only even addresses and only whole pairs of bytes. A byte at an odd start address is therefore split off and written alone with a single-byte program. A lone byte left at the end of the range is written the same way, after a write-disable frame has taken the device out of word mode.

The host gives a start address, a length and a one-cycle `start` pulse, and then waits for `done`. Source bytes are fetched through a byte-read port. `buf_addr` is the offset from the first byte of the range, and `buf_data` must return that byte combinationally in the same cycle.

Top module: `flash_wstream_prog`

## Requirements
- R1: A `start` with `length` zero raises `done` two clock cycles after the `start` cycle, with `error` low and no frame sent (`cs_n` stays high).
- R2: When the start address is odd, the first two frames are a write-enable (one byte 0x06) and a single-byte program (0x02, three address bytes most significant first, then buffer byte 0), and word mode starts at the next address.
- R3: Word mode opens with a write-enable frame followed by a six-byte frame: 0xAD, the even address in three bytes most significant first, then the byte for that address and the byte for the next address.
- R4: Each continuation frame is exactly three bytes: 0xAD followed by the next two buffer bytes in ascending address order, with no address.
- R5: After every program frame (0x02 or 0xAD) the block sends two-byte status frames (0x05, 0x00). It repeats them until the second returned byte has bit 0 clear. The other status bits are ignored, and no other frame is sent in between.
- R6: Continuation frames are sent as long as two or more bytes of the range remain.
- R7: Once fewer than two bytes remain in word mode, the next frame is a one-byte write-disable (0x04), sent before any other command.
- R8: A single remaining trailing byte is written after the write-disable as a write-enable frame, then a 0x02 frame carrying its address and data, then status polling.
- R9: Each frame has its own `cs_n` low period. Between frames `cs_n` stays high for at least two clock cycles.
- R10: SPI mode 0, most significant bit first. `sclk` is low whenever `cs_n` is high, and one `sclk` period lasts two clock cycles. `mosi` changes only while `sclk` is low, and `miso` is sampled at the rising `sclk` edge.
- R11: If `MAX_POLLS` status reads after one program frame all return busy, the block stops. It raises `done` and `error` together, leaves `cs_n` high and sends no further frame.
- R12: `done` is a single-cycle pulse, and `error` is high only in a cycle where `done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a programming run (taken only while idle) |
| start_addr | input | ADDR_W | Flash address of the first byte |
| length | input | LEN_W | Number of bytes to program |
| buf_addr | output | LEN_W | Offset of the source byte being fetched |
| buf_data | input | 8 | Source byte at `buf_addr`, same cycle |
| sclk | output | 1 | Serial clock |
| cs_n | output | 1 | Active-low chip select |
| mosi | output | 1 | Serial data to flash |
| miso | input | 1 | Serial data from flash |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | Busy-poll limit reached, valid with `done` |

## Verification
The checker assumes that `start` arrives only while the block is idle and that reset is applied before the first run. Under those conditions the serial pins, the inter-frame gap and the `done`/`error` pulses obey R9 to R12 in every cycle. The bench pulses `start` once per scenario and waits for `done` before it drives the next one. Its flash model answers status reads with every non-busy bit set and holds busy for a chosen number of reads, which never exceeds the poll limit except in the scenario written to reach it.

// File: rtl/flash_wstream_pkg.sv
package flash_wstream_pkg;

   // command bytes understood by the flash
   localparam logic [7:0] OP_WREN = 8'h06;
   localparam logic [7:0] OP_WRDI = 8'h04;
   localparam logic [7:0] OP_RDSR = 8'h05;
   localparam logic [7:0] OP_BYTE = 8'h02;
   localparam logic [7:0] OP_WORD = 8'hAD;

   typedef enum logic [2:0] {
      FR_WREN,
      FR_WRDI,
      FR_RDSR,
      FR_BYTE,
      FR_WOPEN,
      FR_WCONT
   } frame_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_NEXT,
      ST_LOAD,
      ST_SHIFT,
      ST_GAP
   } state_e;

endpackage

// File: rtl/wstream_shift8.sv
module wstream_shift8 #(
   parameter int BITS = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            go,
   input  logic [BITS-1:0] tx,
   input  logic            miso,
   output logic            sclk,
   output logic            mosi,
   output logic            rx_last,
   output logic            fin
);
   localparam int CW = $clog2(BITS);

   logic [BITS-1:0] sh;
   logic [CW-1:0]   cnt;
   logic            act;

   assign mosi = sh[BITS-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh      <= '0;
         cnt     <= '0;
         act     <= 1'b0;
         sclk    <= 1'b0;
         rx_last <= 1'b0;
         fin     <= 1'b0;
      end else begin
         fin <= 1'b0;
         if (go && !act) begin
            sh   <= tx;
            cnt  <= '0;
            act  <= 1'b1;
            sclk <= 1'b0;
         end else if (act) begin
            if (!sclk) begin
               sclk    <= 1'b1;
               rx_last <= miso;
            end else begin
               sclk <= 1'b0;
               sh   <= {sh[BITS-2:0], 1'b0};
               cnt  <= cnt + CW'(1);
               if (cnt == CW'(BITS-1)) begin
                  act <= 1'b0;
                  fin <= 1'b1;
               end
            end
         end
      end
   end
endmodule

// File: rtl/wstream_poll_guard.sv
module wstream_poll_guard #(
   parameter int MAX_POLLS = 4096
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic hit,
   output logic last
);
   generate
      if (MAX_POLLS == 0) begin : g_unbounded
         assign last = 1'b0;
      end else begin : g_bounded
         localparam int CW = $clog2(MAX_POLLS + 1);
         logic [CW-1:0] cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   cnt <= '0;
            else if (clr) cnt <= '0;
            else if (hit) cnt <= cnt + CW'(1);
         end
         assign last = (cnt == CW'(MAX_POLLS - 1));
      end
   endgenerate
endmodule

// File: rtl/flash_wstream_prog.sv
module flash_wstream_prog
   import flash_wstream_pkg::*;
#(
   parameter int ADDR_W    = 24,
   parameter int LEN_W     = 16,
   parameter int MAX_POLLS = 4096,
   parameter int GAP_CYC   = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [ADDR_W-1:0] start_addr,
   input  logic [LEN_W-1:0]  length,
   output logic [LEN_W-1:0]  buf_addr,
   input  logic [7:0]        buf_data,
   output logic              sclk,
   output logic              cs_n,
   output logic              mosi,
   input  logic              miso,
   output logic              done,
   output logic              error
);
   localparam int AB = ADDR_W / 8;
   localparam int IW = $clog2(AB + 3);
   localparam int GW = $clog2(GAP_CYC + 1);
   localparam logic [IW-1:0] LAST_BYTE = IW'(AB + 1);
   localparam logic [IW-1:0] LAST_OPEN = IW'(AB + 2);

   initial begin
      assert (ADDR_W % 8 == 0 && ADDR_W >= 8) else $error("ADDR_W must be whole bytes");
      assert (LEN_W >= 2) else $error("LEN_W too small");
      assert (GAP_CYC >= 2) else $error("GAP_CYC must be at least 2");
   end

   state_e           state;
   frame_e           kind, pend, pick_kind, pick_pend;
   logic             pick_end, in_word, busy_q, cs_q, done_q, err_q;
   logic [ADDR_W-1:0] pos;
   logic [LEN_W-1:0] idx, rem;
   logic [IW-1:0]    bidx, last_idx;
   logic [GW-1:0]    gcnt;
   logic [7:0]       tx_byte, addr_byte;
   logic             off, go, fin, rx_last, gap_end, g_last, g_clr, g_hit;

   // ---------------- serial engine and poll limit ----------------
   assign go = (state == ST_LOAD);

   wstream_shift8 #(.BITS(8)) i_shift (
      .clk(clk), .rst_n(rst_n), .go(go), .tx(tx_byte), .miso(miso),
      .sclk(sclk), .mosi(mosi), .rx_last(rx_last), .fin(fin)
   );

   assign gap_end = (state == ST_GAP) && (gcnt == GW'(GAP_CYC - 1));
   assign g_clr   = gap_end && (kind == FR_BYTE || kind == FR_WOPEN || kind == FR_WCONT);
   assign g_hit   = gap_end && (kind == FR_RDSR) && busy_q;

   wstream_poll_guard #(.MAX_POLLS(MAX_POLLS)) i_guard (
      .clk(clk), .rst_n(rst_n), .clr(g_clr), .hit(g_hit), .last(g_last)
   );

   // ---------------- frame byte selection ----------------
   always_comb addr_byte = 8'(pos >> (8 * (AB - int'(bidx))));

   always_comb begin
      tx_byte = 8'h00;
      off     = 1'b0;
      case (kind)
         FR_WREN: tx_byte = OP_WREN;
         FR_WRDI: tx_byte = OP_WRDI;
         FR_RDSR: tx_byte = (bidx == '0) ? OP_RDSR : 8'h00;
         FR_BYTE, FR_WOPEN: begin
            if (bidx == '0)              tx_byte = (kind == FR_BYTE) ? OP_BYTE : OP_WORD;
            else if (bidx <= IW'(AB))    tx_byte = addr_byte;
            else begin
               off     = (bidx == LAST_OPEN);
               tx_byte = buf_data;
            end
         end
         default: begin
            if (bidx == '0) tx_byte = OP_WORD;
            else begin
               off     = (bidx == IW'(2));
               tx_byte = buf_data;
            end
         end
      endcase
   end

   assign buf_addr = idx + LEN_W'(off);

   always_comb begin
      case (kind)
         FR_WREN, FR_WRDI: last_idx = '0;
         FR_RDSR:          last_idx = IW'(1);
         FR_BYTE:          last_idx = LAST_BYTE;
         FR_WOPEN:         last_idx = LAST_OPEN;
         default:          last_idx = IW'(2);
      endcase
   end

   // ---------------- next-step choice ----------------
   always_comb begin
      pick_end  = 1'b0;
      pick_kind = FR_WREN;
      pick_pend = FR_BYTE;
      if (in_word) begin
         pick_kind = (rem > LEN_W'(1)) ? FR_WCONT : FR_WRDI;
      end else if (rem == '0) begin
         pick_end = 1'b1;
      end else begin
         pick_pend = (rem > LEN_W'(1) && !pos[0]) ? FR_WOPEN : FR_BYTE;
      end
   end

   // ---------------- sequencer ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         kind    <= FR_WREN;
         pend    <= FR_WREN;
         in_word <= 1'b0;
         pos     <= '0;
         idx     <= '0;
         rem     <= '0;
         bidx    <= '0;
         gcnt    <= '0;
         busy_q  <= 1'b0;
         cs_q    <= 1'b1;
         done_q  <= 1'b0;
         err_q   <= 1'b0;
      end else begin
         done_q <= 1'b0;
         err_q  <= 1'b0;
         case (state)
            ST_IDLE: if (start) begin
               pos     <= start_addr;
               rem     <= length;
               idx     <= '0;
               in_word <= 1'b0;
               state   <= ST_NEXT;
            end
            ST_NEXT: begin
               bidx <= '0;
               if (pick_end) begin
                  done_q <= 1'b1;
                  state  <= ST_IDLE;
               end else begin
                  kind  <= pick_kind;
                  pend  <= pick_pend;
                  state <= ST_LOAD;
               end
            end
            ST_LOAD: begin
               cs_q  <= 1'b0;
               state <= ST_SHIFT;
            end
            ST_SHIFT: if (fin) begin
               if (kind == FR_RDSR && bidx == IW'(1)) busy_q <= rx_last;
               if (bidx == last_idx) begin
                  cs_q  <= 1'b1;
                  gcnt  <= '0;
                  state <= ST_GAP;
               end else begin
                  bidx  <= bidx + IW'(1);
                  state <= ST_LOAD;
               end
            end
            ST_GAP: if (!gap_end) gcnt <= gcnt + GW'(1);
            else begin
               bidx  <= '0;
               state <= ST_LOAD;
               case (kind)
                  FR_WREN: kind <= pend;
                  FR_BYTE: begin
                     pos  <= pos + ADDR_W'(1);
                     idx  <= idx + LEN_W'(1);
                     rem  <= rem - LEN_W'(1);
                     kind <= FR_RDSR;
                  end
                  FR_WOPEN, FR_WCONT: begin
                     pos     <= pos + ADDR_W'(2);
                     idx     <= idx + LEN_W'(2);
                     rem     <= rem - LEN_W'(2);
                     in_word <= 1'b1;
                     kind    <= FR_RDSR;
                  end
                  FR_RDSR: begin
                     if (!busy_q) state <= ST_NEXT;
                     else if (g_last) begin
                        done_q <= 1'b1;
                        err_q  <= 1'b1;
                        state  <= ST_IDLE;
                     end
                  end
                  default: begin
                     in_word <= 1'b0;
                     state   <= ST_NEXT;
                  end
               endcase
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign cs_n  = cs_q;
   assign done  = done_q;
   assign error = err_q;
endmodule

// File: rtl/flash_wstream_prog_chk.sv
module flash_wstream_prog_chk (
   input logic clk,
   input logic rst_n,
   input logic cs_n,
   input logic sclk,
   input logic mosi,
   input logic done,
   input logic error
);
   // R10
   sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |-> !sclk);

   // R10
   mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sclk |-> $stable(mosi));

   // R9
   cs_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cs_n) |=> cs_n);

   // R12
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R12
   err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      error |-> done);

   // R11
   done_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> cs_n);
endmodule

bind flash_wstream_prog flash_wstream_prog_chk i_chk (
   .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk),
   .mosi(mosi), .done(done), .error(error)
);

// File: tb/test_flash_wstream_prog.sv
module test_flash_wstream_prog;
   localparam int MAXP = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [23:0] start_addr = '0;
   logic [15:0] length = '0;
   logic [15:0] buf_addr;
   logic [7:0]  buf_data;
   logic        sclk, cs_n, mosi, miso, done, error;

   always #5 clk = ~clk;

   flash_wstream_prog #(.ADDR_W(24), .LEN_W(16), .MAX_POLLS(MAXP), .GAP_CYC(2)) i_flash_wstream_prog (
      .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
      .length(length), .buf_addr(buf_addr), .buf_data(buf_data),
      .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .miso(miso),
      .done(done), .error(error)
   );

   logic [7:0] mem [0:255];
   assign buf_data = mem[buf_addr[7:0]];

   int n_chk = 0, n_bad = 0;

   // ---------------- flash model ----------------
   logic [7:0]  fb  [0:511][0:7];
   int          fnb [0:511];
   int          nf = 0, bitcnt = 0, cur_byte = 0;
   logic [7:0]  sh;
   bit          in_frame = 0;
   int          busy_left = 0, busy_cfg = 0, sclk_viol = 0;
   realtime     t_hi = 0, gap_min = 1.0e9;

   // status: every bit set except bit 0, which is busy
   assign miso = (!cs_n && in_frame && cur_byte == 1) ?
                 ((bitcnt == 7) ? (busy_left > 0) : 1'b1) : 1'b0;

   always @(negedge cs_n) begin
      in_frame = 1;
      bitcnt   = 0;
      cur_byte = 0;
      if (nf > 0 && ($realtime - t_hi) < gap_min) gap_min = $realtime - t_hi;
   end

   always @(posedge sclk) begin
      if (cs_n) sclk_viol++;
      else if (in_frame) begin
         sh = {sh[6:0], mosi};
         if (bitcnt == 7) begin
            if (cur_byte < 8) fb[nf][cur_byte] = sh;
            cur_byte++;
            bitcnt = 0;
         end else bitcnt++;
      end
   end

   always @(posedge cs_n) begin
      if (in_frame) begin
         fnb[nf] = cur_byte;
         if (fb[nf][0] == 8'h02 || fb[nf][0] == 8'hAD) busy_left = busy_cfg;
         else if (fb[nf][0] == 8'h05 && busy_left > 0) busy_left--;
         if (nf < 511) nf++;
         in_frame = 0;
         t_hi = $realtime;
      end
   end

   // ---------------- expected frames ----------------
   logic [47:0] eb  [0:511];
   int          enb [0:511];
   int          ne = 0;

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   task automatic exp_push(input int n, input logic [47:0] v);
      if (ne < 512) begin
         eb[ne]  = v;
         enb[ne] = n;
         ne++;
      end
   endtask

   task automatic exp_polls(input int busy);
      for (int p = 0; p <= busy; p++) exp_push(2, {8'h05, 8'h00, 32'h0});
   endtask

   task automatic build_expected(input logic [23:0] a, input int len, input int busy);
      logic [23:0] pos = a;
      int rem = len;
      int i = 0;
      ne = 0;
      if (rem == 0) return;
      if (pos[0]) begin
         exp_push(1, {8'h06, 40'h0});
         exp_push(5, {8'h02, pos, mem[i], 8'h00});
         exp_polls(busy);
         pos++; i++; rem--;
      end
      if (rem >= 2) begin
         exp_push(1, {8'h06, 40'h0});
         exp_push(6, {8'hAD, pos, mem[i], mem[i+1]});
         exp_polls(busy);
         pos += 2; i += 2; rem -= 2;
         while (rem >= 2) begin
            exp_push(3, {8'hAD, mem[i], mem[i+1], 24'h0});
            exp_polls(busy);
            pos += 2; i += 2; rem -= 2;
         end
         exp_push(1, {8'h04, 40'h0});
      end
      if (rem == 1) begin
         exp_push(1, {8'h06, 40'h0});
         exp_push(5, {8'h02, pos, mem[i], 8'h00});
         exp_polls(busy);
      end
   endtask

   task automatic compare_frames(input string tag);
      int lim = (nf < ne) ? nf : ne;
      chk(nf == ne, tag, "frame count", 64'(nf), 64'(ne));
      for (int f = 0; f < lim; f++) begin
         logic [47:0] act = '0;
         for (int k = 0; k < 6 && k < fnb[f]; k++) act[8*(5-k) +: 8] = fb[f][k];
         chk(fnb[f] == enb[f] && act == eb[f], tag, $sformatf("frame %0d", f),
             {8'(fnb[f]), 8'h00, act}, {8'(enb[f]), 8'h00, eb[f]});
      end
   endtask

   task automatic launch(input logic [23:0] a, input int len, output int cyc);
      start_addr = a;
      length     = 16'(len);
      start      = 1'b1;
      @(negedge clk);
      start = 1'b0;
      cyc   = 1;
      while (!done && cyc < 60000) begin
         @(negedge clk);
         cyc++;
      end
      if (!done) chk(0, "R12", "done timeout", 64'(cyc), 64'(0));
   endtask

   task automatic prep(input int busy);
      nf        = 0;
      busy_cfg  = busy;
      busy_left = 0;
      gap_min   = 1.0e9;
      sclk_viol = 0;
   endtask

   // ---------------- scenarios ----------------
   task automatic t_reset();
      chk(cs_n == 1'b1, "R9", "cs_n after reset", 64'(cs_n), 64'(1));
      chk(sclk == 1'b0, "R10", "sclk after reset", 64'(sclk), 64'(0));
      chk(done == 1'b0 && error == 1'b0, "R12", "done/error after reset",
          {62'h0, done, error}, 64'(0));
   endtask

   task automatic t_zero();
      int cyc;
      prep(0);
      launch(24'h000123, 0, cyc);
      chk(cyc == 2, "R1", "done latency", 64'(cyc), 64'(2));
      chk(error == 1'b0, "R1", "error on zero length", 64'(error), 64'(0));
      chk(nf == 0, "R1", "frames on zero length", 64'(nf), 64'(0));
   endtask

   task automatic t_run(input logic [23:0] a, input int len, input int busy, input string tag);
      int cyc;
      prep(busy);
      build_expected(a, len, busy);
      launch(a, len, cyc);
      chk(error == 1'b0, "R11", "error on normal run", 64'(error), 64'(0));
      @(negedge clk);
      chk(done == 1'b0, "R12", "done pulse width", 64'(done), 64'(0));
      compare_frames(tag);
      chk(gap_min >= 20.0, "R9", "min cs_n high gap (ns)", 64'(int'(gap_min)), 64'(20));
      chk(sclk_viol == 0, "R10", "sclk edges with cs_n high", 64'(sclk_viol), 64'(0));
   endtask

   task automatic t_timeout();
      int cyc;
      prep(1000);
      ne = 0;
      exp_push(1, {8'h06, 40'h0});
      exp_push(6, {8'hAD, 24'h000200, mem[0], mem[1]});
      for (int p = 0; p < MAXP; p++) exp_push(2, {8'h05, 8'h00, 32'h0});
      launch(24'h000200, 4, cyc);
      chk(error == 1'b1, "R11", "error at poll limit", 64'(error), 64'(1));
      chk(cs_n == 1'b1, "R11", "cs_n at poll limit", 64'(cs_n), 64'(1));
      repeat (60) @(negedge clk);
      compare_frames("R11");
      busy_left = 0;
   endtask

   initial begin
      for (int i = 0; i < 256; i++) mem[i] = 8'(i * 37 + 11);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_zero();
      t_run(24'h123456, 6, 2, "R3 R4 R5 R6 R7");
      t_run(24'h00A0F1, 6, 1, "R2 R6 R7 R8");
      t_run(24'h000011, 2, 0, "R2 R8");
      t_run(24'h000400, 1, 3, "R8 R5");
      t_run(24'hABCDE0, 4, 0, "R3 R4 R7");
      t_timeout();
      t_run(24'h000301, 3, 1, "R2 R3 R7");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      #(200000 * 10);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule